// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits between one processor and the interrupt source logic. It keeps a 32-bit request word: the processor's current priority in the top byte and the number of the pending source in the low 24 bits. Next to that word it keeps the priority of the pending entry and a priority register for software-generated inter-processor interrupts (IPIs). A smaller number means a more favoured priority, and 0xFF means "nothing allowed". Sources offer an interrupt as a number plus a priority. The presenter either takes the offer, which can evict a less favoured pending external source, or sends a reject pulse back to that source.

Software acts on the block through five one-cycle requests: an accepting read, an end-of-interrupt (EOI) write, a write of the current priority, a write of the IPI priority, and, from the source side, an offer. The request word and the IPI register are always visible, which serves as the poll read. A single level output tells the processor that an interrupt is pending. Reject, EOI and resend pulses tell the source side to retry or to retire an interrupt. The built-in IPI source uses the reserved number 2 and competes with external sources by priority.

Top module: `intr_presenter`

## Requirements
- R1: After a synchronous active-low reset the request word is 0, the IPI register is 0xFF, the interrupt output is low, no pulse is active, and the pending priority is 0xFF. An accepting read straight after reset therefore sets the current priority to 0xFF.
- R2: `poll_req` bits 31:24 hold the current priority and bits 23:0 hold the pending source number, where 0 means nothing is pending. `poll_ipi` shows the IPI register. Reading either has no side effect. All state changes appear one clock after the request.
- R3: An offer whose priority is numerically greater than or equal to the current priority is refused. A reject pulse carrying the offered number follows one cycle later, and the state does not change.
- R4: An offer is also refused, in the same way, when an entry is pending whose priority is less than or equal to the offered priority.
- R5: Any other offer is taken. Its number and priority are latched and the output goes high. A displaced external source receives a reject pulse with its own number. A displaced IPI receives none.
- R6: An accepting read returns the current request word. Afterwards the current priority equals the former pending priority, the pending number is 0, the pending priority is 0xFF and the output is low.
- R7: Writing a current priority below the old value, while an entry is pending at a priority greater than or equal to the written value, clears the entry, sets the pending priority to 0xFF and lowers the output. The evicted source gets a reject only if it was external.
- R8: Writing a current priority greater than or equal to the old value while nothing is pending produces a resend pulse. Before that, if the IPI register is below the new current priority, the IPI is loaded.
- R9: Writing the IPI register to a value below the current priority loads an IPI: pending number 2, pending priority equal to the IPI value, output high. The exception is an entry already pending at a priority less than or equal to that value. A displaced external source is rejected.
- R10: An EOI write copies bits 31:24 of its data into the current priority and pulses `eoi_valid` with bits 23:0. If nothing is pending it also pulses `resend_valid`, after re-checking the IPI condition against the new current priority.
- R11: When several requests coincide, only the highest ranked acts, in the order accepting read, EOI, priority write, IPI write, offer. The others are dropped without any pulse.
- R12: The reject, EOI and resend pulses last one cycle per causing request and are low on idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| offer_valid | input | 1 | Source offers an interrupt this cycle |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| cppr_wr | input | 1 | Write current priority |
| cppr_data | input | 8 | New current priority |
| mfrr_wr | input | 1 | Write IPI priority register |
| mfrr_data | input | 8 | New IPI priority |
| accept_rd | input | 1 | Accepting read of the request word |
| eoi_wr | input | 1 | End-of-interrupt write |
| eoi_data | input | 32 | Priority (31:24) and retired source number (23:0) |
| poll_req | output | 32 | Request word: current priority and pending number |
| poll_ipi | output | 8 | IPI priority register |
| irq_out | output | 1 | Interrupt level to the processor |
| rej_valid | output | 1 | Reject pulse to the source side |
| rej_src | output | 24 | Number of the rejected source |
| eoi_valid | output | 1 | EOI pulse to the source side |
| eoi_src | output | 24 | Number carried by the EOI |
| resend_valid | output | 1 | Ask the source side to re-offer held interrupts |

## Verification
The hardest case to reach is a resend that loads an IPI. It needs an empty pending slot, an IPI register already set below a priority that software is about to lower, and then an EOI or priority write that relaxes the priority past it. The bench builds this on purpose. It accepts an IPI, restores a stricter priority, and then issues an EOI at 0xFF. A sweep over current-priority, offer-priority and IPI-value grids then reaches every comparison edge (below, equal, above) for both the refuse and the evict rules.

// File: rtl/ipres_pkg.sv
// Shared definitions for the interrupt presenter.
// Assumes nothing beyond a single clock domain.
package ipres_pkg;
    // Request class acting in one cycle, highest rank first
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_ACCEPT,
        OP_EOI,
        OP_PRIO,
        OP_IPI,
        OP_OFFER
    } op_e;
endpackage

// File: rtl/ipres_op_select.sv
// Picks the one request that acts this cycle.
// Assumes request strobes are one-cycle pulses; lower-ranked coincident
// requests are dropped by the caller.
module ipres_op_select
    import ipres_pkg::*;
(
    input  logic acc_req,
    input  logic eoi_req,
    input  logic prio_req,
    input  logic ipi_req,
    input  logic offer_req,
    output op_e  op
);
    // Fixed-rank priority encode of the request strobes
    always_comb begin
        if (acc_req)        op = OP_ACCEPT;
        else if (eoi_req)   op = OP_EOI;
        else if (prio_req)  op = OP_PRIO;
        else if (ipi_req)   op = OP_IPI;
        else if (offer_req) op = OP_OFFER;
        else                op = OP_IDLE;
    end
endmodule

// File: rtl/ipres_admit.sv
// Admission test shared by external offers and the IPI source.
// A candidate wins when it beats the current priority and is strictly
// more favoured than any entry already pending. Assumes lower value = more favoured.
module ipres_admit #(
    parameter int PRIO_W = 8,
    parameter int SRC_W  = 24
) (
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic [SRC_W-1:0]  pend_src,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic [PRIO_W-1:0] cand_prio,
    output logic              admit
);
    logic busy;

    // Combinational win/lose decision for one candidate
    always_comb begin
        busy  = (pend_src != '0) && (pend_prio <= cand_prio);
        admit = (cand_prio < cur_prio) && !busy;
    end
endmodule

// File: rtl/intr_presenter.sv
// Per-processor interrupt presenter.
// Holds the request word (current priority, pending number), the pending
// priority and the IPI priority register; admits or rejects source offers,
// serves accept/EOI/priority writes and drives the level output plus
// one-cycle reject/EOI/resend pulses. Assumes offered numbers are nonzero
// and differ from the IPI number.
module intr_presenter
    import ipres_pkg::*;
#(
    parameter int SRC_W   = 24,
    parameter int PRIO_W  = 8,
    parameter int IPI_SRC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     offer_valid,
    input  logic [SRC_W-1:0]         offer_src,
    input  logic [PRIO_W-1:0]        offer_prio,
    input  logic                     cppr_wr,
    input  logic [PRIO_W-1:0]        cppr_data,
    input  logic                     mfrr_wr,
    input  logic [PRIO_W-1:0]        mfrr_data,
    input  logic                     accept_rd,
    input  logic                     eoi_wr,
    input  logic [SRC_W+PRIO_W-1:0]  eoi_data,
    output logic [SRC_W+PRIO_W-1:0]  poll_req,
    output logic [PRIO_W-1:0]        poll_ipi,
    output logic                     irq_out,
    output logic                     rej_valid,
    output logic [SRC_W-1:0]         rej_src,
    output logic                     eoi_valid,
    output logic [SRC_W-1:0]         eoi_src,
    output logic                     resend_valid
);
    localparam int REQ_W = SRC_W + PRIO_W;
    localparam logic [PRIO_W-1:0] LEAST  = {PRIO_W{1'b1}};
    localparam logic [SRC_W-1:0]  IPI_NR = SRC_W'(IPI_SRC);

    // State
    logic [PRIO_W-1:0] cur_q, pend_q, ipi_q;
    logic [SRC_W-1:0]  src_q;
    logic              own_q, irq_q;
    logic              rv_q, ev_q, rs_q;
    logic [SRC_W-1:0]  rsrc_q, esrc_q;

    // Next state
    logic [PRIO_W-1:0] cur_d, pend_d, ipi_d;
    logic [SRC_W-1:0]  src_d;
    logic              own_d, irq_d;
    logic              rv_d, ev_d, rs_d;
    logic [SRC_W-1:0]  rsrc_d, esrc_d;

    op_e               op;
    logic [PRIO_W-1:0] eoi_prio;
    logic [PRIO_W-1:0] ipi_cur, ipi_cand;
    logic              offer_ok, ipi_ok;

    assign eoi_prio = eoi_data[REQ_W-1 -: PRIO_W];

    ipres_op_select u_sel (
        .acc_req   (accept_rd),
        .eoi_req   (eoi_wr),
        .prio_req  (cppr_wr),
        .ipi_req   (mfrr_wr),
        .offer_req (offer_valid),
        .op        (op)
    );

    // Current priority the IPI check must see after this cycle's write
    always_comb begin
        case (op)
            OP_EOI:  ipi_cur = eoi_prio;
            OP_PRIO: ipi_cur = cppr_data;
            default: ipi_cur = cur_q;
        endcase
        ipi_cand = (op == OP_IPI) ? mfrr_data : ipi_q;
    end

    ipres_admit #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_offer_admit (
        .cur_prio  (cur_q),
        .pend_src  (src_q),
        .pend_prio (pend_q),
        .cand_prio (offer_prio),
        .admit     (offer_ok)
    );

    ipres_admit #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_ipi_admit (
        .cur_prio  (ipi_cur),
        .pend_src  (src_q),
        .pend_prio (pend_q),
        .cand_prio (ipi_cand),
        .admit     (ipi_ok)
    );

    // Next-state and pulse decode for the single acting request
    always_comb begin
        cur_d  = cur_q;
        pend_d = pend_q;
        ipi_d  = ipi_q;
        src_d  = src_q;
        own_d  = own_q;
        irq_d  = irq_q;
        rv_d   = 1'b0;
        rsrc_d = rsrc_q;
        ev_d   = 1'b0;
        esrc_d = esrc_q;
        rs_d   = 1'b0;
        case (op)
            OP_ACCEPT: begin
                cur_d  = pend_q;
                src_d  = '0;
                pend_d = LEAST;
                own_d  = 1'b0;
                irq_d  = 1'b0;
            end
            OP_EOI: begin
                cur_d  = eoi_prio;
                ev_d   = 1'b1;
                esrc_d = eoi_data[SRC_W-1:0];
                if (src_q == '0) begin
                    rs_d = 1'b1;
                    if (ipi_ok) begin
                        src_d  = IPI_NR;
                        pend_d = ipi_q;
                        own_d  = 1'b0;
                        irq_d  = 1'b1;
                    end
                end
            end
            OP_PRIO: begin
                cur_d = cppr_data;
                if (cppr_data < cur_q) begin
                    if ((src_q != '0) && (cppr_data <= pend_q)) begin
                        rv_d   = own_q;
                        rsrc_d = own_q ? src_q : rsrc_q;
                        src_d  = '0;
                        pend_d = LEAST;
                        own_d  = 1'b0;
                        irq_d  = 1'b0;
                    end
                end else if (src_q == '0) begin
                    rs_d = 1'b1;
                    if (ipi_ok) begin
                        src_d  = IPI_NR;
                        pend_d = ipi_q;
                        own_d  = 1'b0;
                        irq_d  = 1'b1;
                    end
                end
            end
            OP_IPI: begin
                ipi_d = mfrr_data;
                if (ipi_ok) begin
                    rv_d   = (src_q != '0) && own_q;
                    rsrc_d = rv_d ? src_q : rsrc_q;
                    src_d  = IPI_NR;
                    pend_d = mfrr_data;
                    own_d  = 1'b0;
                    irq_d  = 1'b1;
                end
            end
            OP_OFFER: begin
                if (offer_ok) begin
                    rv_d   = (src_q != '0) && own_q;
                    rsrc_d = rv_d ? src_q : rsrc_q;
                    src_d  = offer_src;
                    pend_d = offer_prio;
                    own_d  = 1'b1;
                    irq_d  = 1'b1;
                end else begin
                    rv_d   = 1'b1;
                    rsrc_d = offer_src;
                end
            end
            default: ;
        endcase
    end

    // State registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            src_q  <= '0;
            pend_q <= LEAST;
            ipi_q  <= LEAST;
            own_q  <= 1'b0;
            irq_q  <= 1'b0;
            rv_q   <= 1'b0;
            rsrc_q <= '0;
            ev_q   <= 1'b0;
            esrc_q <= '0;
            rs_q   <= 1'b0;
        end else begin
            cur_q  <= cur_d;
            src_q  <= src_d;
            pend_q <= pend_d;
            ipi_q  <= ipi_d;
            own_q  <= own_d;
            irq_q  <= irq_d;
            rv_q   <= rv_d;
            rsrc_q <= rsrc_d;
            ev_q   <= ev_d;
            esrc_q <= esrc_d;
            rs_q   <= rs_d;
        end
    end

    assign poll_req     = {cur_q, src_q};
    assign poll_ipi     = ipi_q;
    assign irq_out      = irq_q;
    assign rej_valid    = rv_q;
    assign rej_src      = rsrc_q;
    assign eoi_valid    = ev_q;
    assign eoi_src      = esrc_q;
    assign resend_valid = rs_q;

    // R3: refused offer comes back as a reject and leaves the pending slot alone
    a_r3_refuse_low_prio: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_OFFER && offer_prio >= cur_q)
        |=> (rej_valid && rej_src == $past(offer_src) && $stable(src_q)));

    // R5: an admitted offer is latched and raises the output
    a_r5_take_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_OFFER && offer_ok)
        |=> (irq_out && src_q == $past(offer_src) && pend_q == $past(offer_prio)));

    // R6: accepting read hands pending priority to the current priority and empties the slot
    a_r6_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept_rd |=> (!irq_out && src_q == '0 && pend_q == LEAST && cur_q == $past(pend_q)));

    // R10: EOI pulse carries the written number
    a_r10_eoi_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !accept_rd) |=> (eoi_valid && eoi_src == $past(eoi_data[SRC_W-1:0])));

    // R9: an IPI load is never reported as a reject of the IPI number
    a_r9_ipi_no_self_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IPI && ipi_ok && !own_q) |=> !rej_valid);

    // R2: the output level tracks a nonzero pending number
    a_r2_level_matches: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (src_q != '0));
endmodule

// File: tb/intr_presenter_bench.sv
module intr_presenter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_src = '0;
    logic [7:0]  offer_prio = '0;
    logic        cppr_wr = 1'b0;
    logic [7:0]  cppr_data = '0;
    logic        mfrr_wr = 1'b0;
    logic [7:0]  mfrr_data = '0;
    logic        accept_rd = 1'b0;
    logic        eoi_wr = 1'b0;
    logic [31:0] eoi_data = '0;
    logic [31:0] poll_req;
    logic [7:0]  poll_ipi;
    logic        irq_out, rej_valid, eoi_valid, resend_valid;
    logic [23:0] rej_src, eoi_src;

    intr_presenter u_intr_presenter (
        .clk(clk), .rst_n(rst_n),
        .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
        .cppr_wr(cppr_wr), .cppr_data(cppr_data),
        .mfrr_wr(mfrr_wr), .mfrr_data(mfrr_data),
        .accept_rd(accept_rd), .eoi_wr(eoi_wr), .eoi_data(eoi_data),
        .poll_req(poll_req), .poll_ipi(poll_ipi), .irq_out(irq_out),
        .rej_valid(rej_valid), .rej_src(rej_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_valid(resend_valid)
    );

    always #5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Bench-side expectation of the presenter state
    logic [7:0]  m_cur, m_pend, m_ipi;
    logic [23:0] m_src;
    logic        m_own, m_irq;
    logic        e_rv, e_ev, e_rs;
    logic [23:0] e_rsrc, e_esrc;

    task automatic model_reset();
        m_cur = 8'h00; m_pend = 8'hFF; m_ipi = 8'hFF; m_src = '0;
        m_own = 0; m_irq = 0; e_rv = 0; e_ev = 0; e_rs = 0; e_rsrc = '0; e_esrc = '0;
    endtask

    task automatic load_ipi();
        m_src = 24'd2; m_pend = m_ipi; m_own = 0; m_irq = 1;
    endtask

    task automatic chk(string tag);
        logic [74:0] act, exp;
        checks++;
        act = {poll_req, poll_ipi, irq_out, rej_valid, e_rv ? rej_src : 24'h0, eoi_valid, resend_valid};
        exp = {m_cur, m_src, m_ipi, m_irq, e_rv, e_rv ? e_rsrc : 24'h0, e_ev, e_rs};
        if (eoi_valid && e_ev && eoi_src != e_esrc) begin
            errors++;
            $display("FAIL %s eoi_src act=%h exp=%h", tag, eoi_src, e_esrc);
        end else if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One request cycle: acc, eoi, prio write, ipi write, offer
    task automatic step(input bit acc, input bit eo, input bit cw, input bit mw, input bit ov,
                        input logic [31:0] d32, input logic [23:0] s, input logic [7:0] p,
                        input string tag);
        logic [7:0] old;
        @(negedge clk);
        accept_rd = acc; eoi_wr = eo; cppr_wr = cw; mfrr_wr = mw; offer_valid = ov;
        eoi_data = d32; cppr_data = p; mfrr_data = p; offer_src = s; offer_prio = p;
        e_rv = 0; e_ev = 0; e_rs = 0;
        if (acc) begin
            m_cur = m_pend; m_src = '0; m_pend = 8'hFF; m_own = 0; m_irq = 0;
        end else if (eo) begin
            m_cur = d32[31:24]; e_ev = 1; e_esrc = d32[23:0];
            if (m_src == 0) begin
                e_rs = 1;
                if (m_ipi < m_cur) load_ipi();
            end
        end else if (cw) begin
            old = m_cur; m_cur = p;
            if (p < old) begin
                if (m_src != 0 && p <= m_pend) begin
                    if (m_own) begin e_rv = 1; e_rsrc = m_src; end
                    m_src = '0; m_pend = 8'hFF; m_own = 0; m_irq = 0;
                end
            end else if (m_src == 0) begin
                e_rs = 1;
                if (m_ipi < m_cur) load_ipi();
            end
        end else if (mw) begin
            m_ipi = p;
            if (p < m_cur && !(m_src != 0 && m_pend <= p)) begin
                if (m_src != 0 && m_own) begin e_rv = 1; e_rsrc = m_src; end
                load_ipi();
            end
        end else if (ov) begin
            if (p < m_cur && !(m_src != 0 && m_pend <= p)) begin
                if (m_src != 0 && m_own) begin e_rv = 1; e_rsrc = m_src; end
                m_src = s; m_pend = p; m_own = 1; m_irq = 1;
            end else begin
                e_rv = 1; e_rsrc = s;
            end
        end
        @(posedge clk);
        #1;
        accept_rd = 0; eoi_wr = 0; cppr_wr = 0; mfrr_wr = 0; offer_valid = 0;
        chk(tag);
    endtask

    task automatic t_acc(input string tag); step(1,0,0,0,0, '0, '0, '0, tag); endtask
    task automatic t_idle(); step(0,0,0,0,0, '0, '0, '0, "R12 idle"); endtask
    task automatic t_eoi(input logic [31:0] d); step(0,1,0,0,0, d, '0, '0, "R10"); endtask
    task automatic t_mfrr(input logic [7:0] p); step(0,0,0,1,0, '0, '0, p, "R9"); endtask
    task automatic t_cppr(input logic [7:0] p);
        string t;
        t = (p < m_cur) ? "R7" : "R8";
        step(0,0,1,0,0, '0, '0, p, t);
    endtask
    task automatic t_offer(input logic [23:0] s, input logic [7:0] p);
        string t;
        if (p >= m_cur) t = "R3";
        else if (m_src != 0 && m_pend <= p) t = "R4";
        else t = "R5";
        step(0,0,0,0,1, '0, s, p, t);
    endtask

    logic [7:0] cps [0:4];
    logic [7:0] ops [0:6];
    logic [7:0] ips [0:5];

    // Watchdog: a hung run is one failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cps = '{8'h00, 8'h10, 8'h80, 8'hFE, 8'hFF};
        ops = '{8'h00, 8'h0F, 8'h10, 8'h11, 8'h80, 8'hFE, 8'hFF};
        ips = '{8'h00, 8'h20, 8'h3F, 8'h40, 8'h41, 8'hFF};
        model_reset();
        repeat (3) @(posedge clk);
        #1; chk("R1 reset");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1; chk("R1 after release");
        t_acc("R1 accept after reset gives 0xFF");

        // Offer sweep over current and offered priorities, with eviction
        foreach (cps[i]) begin
            foreach (ops[j]) begin
                t_acc("R6");
                t_cppr(cps[i]);
                t_offer(24'h100 + 24'(j), ops[j]);
                if (ops[j] != 8'h00) t_offer(24'h200 + 24'(j), ops[j] - 8'h1);
                t_offer(24'h300, ops[j]);
                t_idle();
            end
        end

        // IPI sweep against current priority and a pending external at 0x40
        foreach (cps[i]) begin
            foreach (ips[k]) begin
                t_mfrr(8'hFF);
                t_acc("R6");
                t_cppr(cps[i]);
                t_offer(24'h55, 8'h40);
                t_mfrr(ips[k]);
                t_idle();
            end
        end

        // Directed EOI / resend / IPI displacement sequence
        t_mfrr(8'hFF);
        t_acc("R6");
        t_cppr(8'hFF);
        t_offer(24'h77, 8'h30);
        step(0,0,0,0,0, '0, '0, '0, "R2 poll no side effect");
        t_acc("R6 accept external");
        t_eoi({8'hFF, 24'h77});
        t_mfrr(8'h50);
        t_acc("R6 accept ipi");
        t_eoi({8'h10, 24'h2});
        t_eoi({8'hFF, 24'h2});           // R10: resend re-check loads IPI
        t_offer(24'h88, 8'h20);          // R5: displaced IPI gets no reject
        t_cppr(8'h10);                   // R7: evict external with reject
        t_cppr(8'hFF);                   // R8: resend plus IPI load
        t_cppr(8'h40);                   // R7: evict IPI silently
        t_idle();

        // R11: precedence when requests coincide
        t_cppr(8'hFF);
        step(1,0,0,0,1, '0, 24'h99, 8'h05, "R11 accept beats offer");
        step(0,1,1,0,0, {8'h20, 24'h44}, '0, 8'h00, "R11 eoi beats prio write");
        step(0,0,1,1,1, '0, 24'h66, 8'h30, "R11 prio write beats ipi and offer");
        step(0,0,0,1,1, '0, 24'h66, 8'h08, "R11 ipi write beats offer");
        t_idle();
        t_idle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule